// File: doc/BRIEF.md
# Call Return Frame Sequencer

This block carries out the stack side of subroutine linkage for a small 32-bit core. On a start strobe it runs one of five operations: a call to an absolute target, a call to a target held in a register, a return, a single-register push or a single-register pop. A call lays down a three-word frame on a full-descending stack. The highest word is a reserved slot that is never written. Below it sits the return address, and below that the caller's frame pointer. The frame pointer and the stack pointer both end up pointing at the lowest word. A return finds the frame through the frame pointer alone. It restores the saved frame pointer and the return address, then moves the stack pointer past all three words.

The decoder outside the block chooses the operation and supplies the call target, the current PC and the values of the frame pointer, the stack pointer and the two general registers named by the instruction. The block moves one word per cycle over a simple memory port that answers in the same cycle and may report a fault. All register results stay in the block until the operation completes. They then appear together with per-register write enables and a one-cycle done pulse. A faulted operation writes no register and raises a fault pulse instead.

Top module: `frame_seq`

## Requirements
- R1: With op = 0 (call, absolute target), the block writes PC+6 at SP-8 and the old FP at SP-12, leaves SP-4 unwritten, then returns PC = target and SP = FP = SP-12 with pc_we, fp_we and sp_we high.
- R2: With op = 1 (call, register target), the behaviour is as in R1 except that the return address written at SP-8 is PC+2.
- R3: With op = 2 (return), the block reads the new FP from address FP and the new PC from FP+4, then returns SP = FP+12 with pc_we, fp_we and sp_we high.
- R4: With op = 3 (push), the block writes register B at A-4 and returns A = A-4 with only a_we high.
- R5: With op = 4 (pop), the block reads the word at A into B and returns A = A+4 with only a_we and b_we high.
- R6: If start is sampled at clock edge k, call and return raise done during the single cycle after edge k+2, and push and pop during the single cycle after edge k+1. Write enables are high only in that done cycle, and mem_req is high in each transfer cycle in between.
- R7: If mem_fault is high in a transfer cycle, the operation stops. No further memory request is made, done is not raised, no write enable is raised, and fault is high for one cycle in the cycle after that edge.
- R8: A start while an operation is in progress is ignored, and op codes 5 to 7 are ignored: neither makes a memory request or raises done.
- R9: After reset, done, fault, mem_req and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op | input | 3 | 0 call absolute, 1 call register, 2 return, 3 push, 4 pop |
| target | input | 32 | Call target address |
| pc_in | input | 32 | PC of the current instruction |
| fp_in | input | 32 | Current frame pointer |
| sp_in | input | 32 | Current stack pointer |
| a_in | input | 32 | Stack register A for push and pop |
| b_in | input | 32 | Data register B for push |
| mem_req | output | 1 | Memory transfer this cycle |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle |
| mem_fault | input | 1 | Transfer failed |
| done | output | 1 | Operation completed |
| fault | output | 1 | Operation aborted by a memory fault |
| pc_we | output | 1 | Load pc_out into PC |
| pc_out | output | 32 | Next PC |
| fp_we | output | 1 | Load fp_out into the frame pointer |
| fp_out | output | 32 | New frame pointer |
| sp_we | output | 1 | Load sp_out into the stack pointer |
| sp_out | output | 32 | New stack pointer |
| a_we | output | 1 | Load a_out into register A |
| a_out | output | 32 | New value of register A |
| b_we | output | 1 | Load b_out into register B |
| b_out | output | 32 | New value of register B |

## Verification
Start is sampled at a rising edge. A call or a return then reports done in the third cycle after that edge, and a push or a pop in the second. A fault in the last transfer is reported in the cycle where done would have appeared. The bench drives and samples only on falling edges. It counts falling edges from the start edge until done or fault appears, compares the count with these figures, and reads the result registers and write enables at that same falling edge. Memory effects are read from the bench's own memory model after completion, and one-cycle pulses are confirmed by sampling the following falling edge.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int DW      = 32,
  parameter int LEN_ABS = 6,
  parameter int LEN_REG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] fp_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_fault,
  output logic          done,
  output logic          fault,
  output logic          pc_we,
  output logic [DW-1:0] pc_out,
  output logic          fp_we,
  output logic [DW-1:0] fp_out,
  output logic          sp_we,
  output logic [DW-1:0] sp_out,
  output logic          a_we,
  output logic [DW-1:0] a_out,
  output logic          b_we,
  output logic [DW-1:0] b_out
);
  localparam logic [DW-1:0] WB   = DW'(DW / 8);
  localparam logic [DW-1:0] WB2  = DW'(2 * (DW / 8));
  localparam logic [DW-1:0] WB3  = DW'(3 * (DW / 8));
  localparam logic [DW-1:0] LABS = DW'(LEN_ABS);
  localparam logic [DW-1:0] LREG = DW'(LEN_REG);

  typedef enum logic [2:0] {IDLE, CW1, CW2, RR1, RR2, PU, PO} st_t;

  st_t           st;
  logic [DW-1:0] ptr, dat, aux, sfp;

  assign mem_req   = (st != IDLE);
  assign mem_we    = (st == CW1) || (st == CW2) || (st == PU);
  assign mem_addr  = (st == CW2) ? ptr - WB : (st == RR2) ? ptr + WB : ptr;
  assign mem_wdata = (st == CW2) ? sfp : dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      {ptr, dat, aux, sfp} <= '0;
      {done, fault, pc_we, fp_we, sp_we, a_we, b_we} <= '0;
      {pc_out, fp_out, sp_out, a_out, b_out} <= '0;
    end else begin
      {done, fault, pc_we, fp_we, sp_we, a_we, b_we} <= '0;
      if (st == IDLE) begin
        if (start) begin
          case (op)
            3'd0, 3'd1: begin
              ptr <= sp_in - WB2;
              dat <= pc_in + ((op == 3'd0) ? LABS : LREG);
              aux <= target;
              sfp <= fp_in;
              st  <= CW1;
            end
            3'd2: begin ptr <= fp_in; st <= RR1; end
            3'd3: begin ptr <= a_in - WB; dat <= b_in; st <= PU; end
            3'd4: begin ptr <= a_in; st <= PO; end
            default: ;
          endcase
        end
      end else if (mem_fault) begin
        st    <= IDLE;
        fault <= 1'b1;
      end else begin
        case (st)
          CW1: st <= CW2;
          CW2: begin
            st <= IDLE; done <= 1'b1;
            pc_out <= aux; fp_out <= ptr - WB; sp_out <= ptr - WB;
            {pc_we, fp_we, sp_we} <= 3'b111;
          end
          RR1: begin dat <= mem_rdata; st <= RR2; end
          RR2: begin
            st <= IDLE; done <= 1'b1;
            pc_out <= mem_rdata; fp_out <= dat; sp_out <= ptr + WB3;
            {pc_we, fp_we, sp_we} <= 3'b111;
          end
          PU: begin
            st <= IDLE; done <= 1'b1;
            a_out <= ptr; a_we <= 1'b1;
          end
          PO: begin
            st <= IDLE; done <= 1'b1;
            a_out <= ptr + WB; b_out <= mem_rdata;
            {a_we, b_we} <= 2'b11;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          done,
  input logic          fault,
  input logic          pc_we,
  input logic          fp_we,
  input logic          sp_we,
  input logic          a_we,
  input logic          b_we
);
  localparam logic [DW-1:0] WB = DW'(DW / 8);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R6
  we_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we || fp_we || sp_we || a_we || b_we) |-> done);

  // R7
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) fault |-> !done);

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) fault |-> !mem_req);

  // R1
  call_push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && mem_we)) |-> (mem_addr == $past(mem_addr) - WB));

  // R3
  ret_read_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req && !mem_we)) |-> (mem_addr == $past(mem_addr) + WB));

  // R9
  we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_req);
endmodule

bind frame_seq frame_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .done(done), .fault(fault), .pc_we(pc_we), .fp_we(fp_we), .sp_we(sp_we),
  .a_we(a_we), .b_we(b_we)
);

// File: tb/frame_seq_bench.sv
`timescale 1ns/100ps
module frame_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op = '0;
  logic [31:0] target = '0, pc_in = '0, fp_in = '0, sp_in = '0, a_in = '0, b_in = '0;
  logic mem_req, mem_we, mem_fault, done, fault;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic pc_we, fp_we, sp_we, a_we, b_we;
  logic [31:0] pc_out, fp_out, sp_out, a_out, b_out;

  logic [31:0] mem [64];
  logic        flt_en = 1'b0;
  logic [31:0] flt_addr = '0;
  int nchk = 0, nfail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  frame_seq u_frame_seq (.*);

  assign mem_rdata = mem[mem_addr[7:2]];
  assign mem_fault = mem_req && flt_en && (mem_addr == flt_addr);
  always @(posedge clk) if (mem_req && mem_we && !mem_fault) mem[mem_addr[7:2]] <= mem_wdata;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nfail++;
      $display("FAIL R6 watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] wes();
    return {pc_we, fp_we, sp_we, a_we, b_we};
  endfunction

  task automatic run(input logic [2:0] o, input logic [31:0] p, t, f, s, ra, rb,
                     output int n, output bit gd, output bit gf, output bit rq);
    @(negedge clk);
    op = o; pc_in = p; target = t; fp_in = f; sp_in = s; a_in = ra; b_in = rb; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1; gd = done; gf = fault; rq = mem_req;
    while (!gd && !gf && n < 12) begin
      @(negedge clk);
      n++; gd = done; gf = fault; rq = rq | mem_req;
    end
  endtask

  // columns: op, pc, target, fp, sp, a, b, latency
  localparam logic [31:0] VT [0:5][0:7] = '{
    '{32'd0, 32'h1000, 32'h2000, 32'h80, 32'hF0, 32'h0,  32'h0,         32'd3},
    '{32'd2, 32'h2000, 32'h0,    32'hE4, 32'hE4, 32'h0,  32'h0,         32'd3},
    '{32'd1, 32'h3000, 32'h4444, 32'h40, 32'hC0, 32'h0,  32'h0,         32'd3},
    '{32'd2, 32'h4444, 32'h0,    32'hB4, 32'hB4, 32'h0,  32'h0,         32'd3},
    '{32'd3, 32'h0,    32'h0,    32'h0,  32'h0,  32'h60, 32'hDEADBEEF,  32'd2},
    '{32'd4, 32'h0,    32'h0,    32'h0,  32'h0,  32'h5C, 32'h0,         32'd2}
  };

  initial begin
    int n;
    bit gd, gf, rq;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "done", {31'd0, done}, 32'd0);
    chk("R9", "fault", {31'd0, fault}, 32'd0);
    chk("R9", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R9", "write enables", {27'd0, wes()}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      logic [31:0] o, p, t, f, s, ra, rb;
      logic [31:0] e_pc, e_fp, e_sp, e_a, e_b;
      logic [4:0]  e_we;
      string tag;
      o = VT[v][0]; p = VT[v][1]; t = VT[v][2]; f = VT[v][3];
      s = VT[v][4]; ra = VT[v][5]; rb = VT[v][6];
      e_pc = 'x; e_fp = 'x; e_sp = 'x; e_a = 'x; e_b = 'x;
      case (o)
        0, 1: begin
          tag = (o == 0) ? "R1" : "R2";
          mem[(s - 4) >> 2] = 32'hA5A5A5A5;
          e_pc = t; e_fp = s - 12; e_sp = s - 12; e_we = 5'b11100;
        end
        2: begin
          tag = "R3";
          e_fp = mem[f >> 2]; e_pc = mem[(f + 4) >> 2]; e_sp = f + 12; e_we = 5'b11100;
        end
        3: begin tag = "R4"; e_a = ra - 4; e_we = 5'b00010; end
        default: begin tag = "R5"; e_b = mem[ra >> 2]; e_a = ra + 4; e_we = 5'b00011; end
      endcase
      run(o[2:0], p, t, f, s, ra, rb, n, gd, gf, rq);
      chk("R6", {tag, " latency"}, n, VT[v][7]);
      chk(tag, "done", {31'd0, gd}, 32'd1);
      chk(tag, "write enables", {27'd0, wes()}, {27'd0, e_we});
      if (e_we[4]) chk(tag, "pc_out", pc_out, e_pc);
      if (e_we[3]) chk(tag, "fp_out", fp_out, e_fp);
      if (e_we[2]) chk(tag, "sp_out", sp_out, e_sp);
      if (e_we[1]) chk(tag, "a_out", a_out, e_a);
      if (e_we[0]) chk(tag, "b_out", b_out, e_b);
      if (o <= 1) begin
        chk(tag, "return address at SP-8", mem[(s - 8) >> 2], p + ((o == 0) ? 32'd6 : 32'd2));
        chk(tag, "saved FP at SP-12", mem[(s - 12) >> 2], f);
        chk(tag, "static slot untouched", mem[(s - 4) >> 2], 32'hA5A5A5A5);
      end
      if (o == 3) chk("R4", "pushed word", mem[(ra - 4) >> 2], rb);
      @(negedge clk);
      chk("R6", {tag, " done single cycle"}, {31'd0, done}, 32'd0);
    end

    // R7: fault on the second write of a call
    flt_en = 1'b1; flt_addr = 32'h70 - 12;
    run(3'd0, 32'h800, 32'h900, 32'h10, 32'h70, 32'h0, 32'h0, n, gd, gf, rq);
    chk("R7", "call fault latency", n, 32'd3);
    chk("R7", "call fault flag", {31'd0, gf}, 32'd1);
    chk("R7", "call no done", {31'd0, gd}, 32'd0);
    chk("R7", "call no writes", {27'd0, wes()}, 32'd0);
    chk("R7", "no request after fault", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    chk("R7", "fault single cycle", {31'd0, fault}, 32'd0);

    // R7: fault on a pop read
    flt_addr = 32'h20;
    run(3'd4, 32'h0, 32'h0, 32'h0, 32'h0, 32'h20, 32'h0, n, gd, gf, rq);
    chk("R7", "pop fault latency", n, 32'd2);
    chk("R7", "pop fault flag", {31'd0, gf}, 32'd1);
    chk("R7", "pop no writes", {27'd0, wes()}, 32'd0);
    flt_en = 1'b0;

    // R8: start during a call is ignored
    mem[(32'h40 - 4) >> 2] = 32'h0;
    @(negedge clk);
    op = 3'd0; pc_in = 32'h500; target = 32'h600; fp_in = 32'h10; sp_in = 32'hA0; start = 1'b1;
    @(negedge clk);
    op = 3'd3; a_in = 32'h40; b_in = 32'h12345678;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R8", "busy start call done", {31'd0, done}, 32'd1);
    chk("R8", "busy start call pc", pc_out, 32'h600);
    chk("R8", "busy start write enables", {27'd0, wes()}, 32'b11100);
    rq = 1'b0; gd = 1'b0;
    repeat (3) begin
      @(negedge clk);
      rq = rq | mem_req; gd = gd | done;
    end
    chk("R8", "no request after busy start", {31'd0, rq}, 32'd0);
    chk("R8", "no second done", {31'd0, gd}, 32'd0);
    chk("R8", "ignored push left memory", mem[(32'h40 - 4) >> 2], 32'h0);

    // R8: unused op code
    run(3'd5, 32'h0, 32'h0, 32'h0, 32'h0, 32'h40, 32'h55, n, gd, gf, rq);
    chk("R8", "op 5 no done", {31'd0, gd}, 32'd0);
    chk("R8", "op 5 no request", {31'd0, rq}, 32'd0);
    chk("R8", "op 5 no fault", {31'd0, gf}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule